// File: doc/BRIEF.md
# UART Interrupt Enable and Source Masking

This block holds the interrupt enable byte of a 16550-style serial port and uses it to mask the port's four raw interrupt conditions. Those conditions come from the surrounding port logic. Bit 0 of the input vector is received data available or character timeout. Bit 1 is transmit holding register empty. Bit 2 is receiver line status. Bit 3 is modem status.

Each condition is ANDed with its enable bit. The surviving conditions form a masked pending vector. That vector feeds two things: a priority encoder that produces the identification code, and a registered, active-high interrupt line.

Masking only hides a source. The raw conditions keep changing while their enables are cleared, and re-enabling a source shows its current state at once.

The register bus is plain. A write strobe loads the byte on the clock edge, and the read data always shows the stored byte. Every write is accepted, so there is no back-pressure and no handshake. The upper nibble of the register is not stored and always reads as zero.

Top module: `uart_irq_mask`

## Requirements
- R1: After reset the enable register reads 0x00, `irq` is 0, `pend` is 0000 and `id_code` is 0001.
- R2: A write (`wr_en` high at a rising edge) stores `wr_data[3:0]`. From the next cycle on, `rd_data[3:0]` shows those bits.
- R3: `rd_data[7:4]` always reads 0, whatever was written to `wr_data[7:4]`.
- R4: Enable bit 0 masks received data/timeout (`raw[0]`). Bit 1 masks transmit empty (`raw[1]`). Bit 2 masks line status (`raw[2]`). Bit 3 masks modem status (`raw[3]`). `pend[i]` uses the same bit positions.
- R5: `irq` is a register. In each cycle it equals the OR of `pend` from the previous cycle.
- R6: A source whose enable bit is 0 never appears in `pend` or `id_code`, and never causes `irq`, even while its raw condition is active.
- R7: `id_code` reports the highest-priority pending source. The codes, from highest to lowest priority, are: line status 0110, received data/timeout 0100, transmit empty 0010, modem status 0000. The code 0001 means nothing is pending.
- R8: With the enable register at zero, `pend` is 0000, `id_code` is 0001 and `irq` stays 0 for any `raw` pattern.
- R9: Suppose an enable bit is written while its raw condition is already active. `pend` shows the source in the cycle after the write, and `irq` rises one cycle after that.
- R10: While a source is masked, its raw condition is still followed. If it is re-enabled with the condition still active, it is pending again straight away. Clearing the enable drops `irq` one cycle after `pend` clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Enable register read data |
| raw | input | 4 | Raw interrupt conditions |
| pend | output | 4 | Masked pending vector |
| id_code | output | 4 | Identification code of the top pending source |
| irq | output | 1 | Registered interrupt output, active high |

## Verification
The assertions check several rules on every cycle:
- No masked source ever shows in the pending vector.
- The upper read nibble stays zero.
- A write is reflected in the read data on the next cycle.
- The interrupt line follows the OR of the previous cycle's pending vector.
- Line status always wins the identification code.
- An all-zero enable keeps the code at "none".

Some behaviours only show up in the bench's scenarios:
- The full priority ordering across mixed patterns.
- The two-cycle timing from enabling an already-active source to the interrupt.
- Raw conditions that change while masked being seen correctly after re-enable.
- A reset in mid-run clearing the register.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N   = 4;
  localparam int SRC_RX  = 0;
  localparam int SRC_THR = 1;
  localparam int SRC_LS  = 2;
  localparam int SRC_MS  = 3;

  typedef enum logic [3:0] {
    ID_MS   = 4'b0000,
    ID_NONE = 4'b0001,
    ID_THR  = 4'b0010,
    ID_RX   = 4'b0100,
    ID_LS   = 4'b0110
  } irq_id_e;
endpackage

// File: rtl/uart_ien_reg.sv
module uart_ien_reg #(
  parameter int DW   = 8,
  parameter int EN_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [EN_W-1:0] en_q,
  output logic [DW-1:0]   rd_data
);
  // Bits above EN_W are never stored.
  logic unused_hi;
  assign unused_hi = ^wr_data[DW-1:EN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_data[EN_W-1:0];
  end

  assign rd_data = DW'(en_q);
endmodule

// File: rtl/uart_irq_gate.sv
module uart_irq_gate #(
  parameter int N = 4
) (
  input  logic [N-1:0] raw,
  input  logic [N-1:0] en,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_mask
    assign pend[i] = raw[i] & en[i];
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [SRC_N-1:0] pend,
  output irq_id_e          id,
  output logic             any
);
  always_comb begin
    if      (pend[SRC_LS])  id = ID_LS;
    else if (pend[SRC_RX])  id = ID_RX;
    else if (pend[SRC_THR]) id = ID_THR;
    else if (pend[SRC_MS])  id = ID_MS;
    else                    id = ID_NONE;
  end
  assign any = |pend;
endmodule

// File: rtl/uart_irq_mask.sv
module uart_irq_mask
  import uart_irq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [SRC_N-1:0] raw,
  output logic [SRC_N-1:0] pend,
  output logic [3:0]       id_code,
  output logic             irq
);
  logic [SRC_N-1:0] en_q;
  irq_id_e          id_e;
  logic             any_pend;

  uart_ien_reg #(.DW(DW), .EN_W(SRC_N)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .en_q(en_q), .rd_data(rd_data)
  );

  uart_irq_gate #(.N(SRC_N)) u_gate (
    .raw(raw), .en(en_q), .pend(pend)
  );

  uart_irq_prio u_prio (
    .pend(pend), .id(id_e), .any(any_pend)
  );

  assign id_code = id_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_pend;
  end
endmodule

// File: rtl/uart_irq_mask_chk.sv
module uart_irq_mask_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic [3:0]    pend,
  input logic [3:0]    id_code,
  input logic          irq
);
  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[3:0] == $past(wr_data[3:0]));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:4] == '0);

  a_r6_masked_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~rd_data[3:0]) == 4'b0000);

  a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|pend));

  a_r7_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    pend[2] |-> id_code == 4'b0110);

  a_r8_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3:0] == 4'b0000 |-> (pend == 4'b0000 && id_code == 4'b0001));
endmodule

bind uart_irq_mask uart_irq_mask_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pend(pend), .id_code(id_code), .irq(irq)
);

// File: tb/uart_irq_mask_test.sv
`timescale 1ns/1ps
module uart_irq_mask_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [3:0] raw = 4'h0;
  logic [3:0] pend;
  logic [3:0] id_code;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_mask uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .raw(raw), .pend(pend), .id_code(id_code), .irq(irq)
  );

  // {enable, raw, expected pend, expected id}
  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    16'hFF_F6, 16'hFB_B4, 16'hFA_A2, 16'hF8_80, 16'h0F_01, 16'h3C_01,
    16'hCF_C6, 16'h8F_80, 16'h23_22, 16'h55_56, 16'hF0_01
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #20000;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state
    #12;
    check("R1 rd", rd_data, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 id", {4'b0, id_code}, 8'h01);
    check("R1 pend", {4'b0, pend}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: R2 R3 R4 R6 R7 R8 R5
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = {4'hA, VEC[i][15:12]};
      raw = VEC[i][11:8];
      @(negedge clk);
      wr_en = 1'b0;
      check("R2/R3 rd", rd_data, {4'h0, VEC[i][15:12]});
      check("R4/R6 pend", {4'b0, pend}, {4'b0, VEC[i][7:4]});
      check("R7/R8 id", {4'b0, id_code}, {4'b0, VEC[i][3:0]});
      @(negedge clk);
      check("R5 irq", {7'b0, irq}, {7'b0, |VEC[i][7:4]});
    end

    // R8: all disabled, every raw pattern
    wr(8'h00);
    for (int r = 0; r < 16; r++) begin
      raw = 4'(r);
      @(negedge clk);
      check("R8 pend", {4'b0, pend}, 8'h00);
      check("R8 id", {4'b0, id_code}, 8'h01);
      check("R8 irq", {7'b0, irq}, 8'h00);
    end

    // R9: enable an already-active source
    raw = 4'b0010;
    @(negedge clk);
    wr(8'h02);
    check("R9 pend", {4'b0, pend}, 8'h02);
    check("R9 irq early", {7'b0, irq}, 8'h00);
    @(negedge clk);
    check("R9 irq", {7'b0, irq}, 8'h01);

    // R10: masked source keeps tracking raw, returns on re-enable
    wr(8'h00);
    check("R10 pend off", {4'b0, pend}, 8'h00);
    check("R10 irq hold", {7'b0, irq}, 8'h01);
    @(negedge clk);
    check("R10 irq drop", {7'b0, irq}, 8'h00);
    raw = 4'b0100;
    @(negedge clk);
    raw = 4'b0101;
    wr(8'h04);
    check("R10 pend back", {4'b0, pend}, 8'h04);
    check("R10 id", {4'b0, id_code}, 8'h06);

    // R1: reset in mid-run clears register
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid rd", rd_data, 8'h00);
    check("R1 mid irq", {7'b0, irq}, 8'h00);
    check("R1 mid id", {4'b0, id_code}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule